// File: doc/BRIEF.md
# Board Link Reset Sequencer

This block brings up a host bridge and the remote expansion chassis that sits behind it on a serial link. A one-cycle `start` pulse begins a fixed sequence. The block holds the bridge local-bus reset for a set number of microseconds and then lets the bridge settle. After that it polls the link. Each poll attempt issues a status-write strobe, which tells the surrounding logic to write zero into the link status register. The block then waits a few microseconds and samples the link-error bit. When the link reports up, the block resets the remote chassis with two strobes: an enable strobe, then a disable strobe a fixed number of microseconds later.

All timing is counted in pulses of an external microsecond tick (`us_tick`), so the block does not depend on the system clock frequency. If the link stays in error for the whole attempt budget, the sequence ends with `fail` raised and the remote chassis is never reset. In both outcomes, `done` pulses once when the sequence ends.

Top module: `link_reset_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it falls, the outputs `bridge_rst`, `stat_wr`, `remote_rst_en`, `remote_rst_dis`, `done` and `fail` are all 0. The block then sits idle until a `start` pulse arrives.
- R2: A `start` pulse in idle raises `bridge_rst` in the next cycle. `bridge_rst` stays high through exactly BRIDGE_US `us_tick` pulses (default 10) and then falls. Exactly SETTLE_US further tick pulses (default 10) pass before the first `stat_wr`.
- R3: Each link attempt is a `stat_wr` pulse one cycle wide. `link_err` is sampled on the POLL_US-th tick after that pulse (default 5). A value of 0 means the link is up and polling stops. A value of 1 starts the next attempt.
- R4: At most MAX_TRIES attempts are made (default 1000). If every sample reads 1, then `fail` rises, `done` pulses, and neither remote strobe is issued.
- R5: After the link-up sample, `remote_rst_en` pulses for one cycle. `remote_rst_dis` then pulses for one cycle after exactly GAP_US further tick pulses (default 5).
- R6: `done` is a one-cycle pulse. On success it comes in the cycle after `remote_rst_dis`. On exhaustion it comes together with the rise of `fail`. `fail` stays high until the next accepted `start` or `rst`, and stays 0 after a successful sequence.
- R7: A `start` pulse that arrives while a sequence is running is ignored. It does not restart the bridge reset and does not change the sequence.
- R8: A `rst` pulse in the middle of a sequence aborts it. All outputs are 0 in the next cycle, including `fail` from an earlier failure, and no further strobes appear until a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| link_err | input | 1 | Link-error status bit; 0 means the link is up |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bridge_rst | output | 1 | Bridge local-bus reset |
| stat_wr | output | 1 | Strobe to write zero into the link status register |
| remote_rst_en | output | 1 | Remote chassis reset-enable strobe |
| remote_rst_dis | output | 1 | Remote chassis reset-disable strobe |
| done | output | 1 | One-cycle pulse when the sequence ends |
| fail | output | 1 | Link was never established within the attempt budget |

## Verification
A wrong state encoding or a bad transition shows at the ports within one cycle, because every output decodes directly from the state register. Such faults appear as a strobe two cycles wide, a strobe overlapping `bridge_rst`, or a missing `done`. A tick counter that is off by one shows up one microsecond later, as a bridge-reset width, settle window, poll interval or strobe gap that is one tick short or long. The bench measures each of these windows in ticks. A fault in the attempt counter only appears at the end of an exhausted run, as a wrong number of `stat_wr` pulses. For that reason the bench runs the full default budget twice.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BRST,
        ST_SETTLE,
        ST_WR,
        ST_POLL,
        ST_REN,
        ST_GAP,
        ST_RDIS,
        ST_FIN
    } lrs_state_e;

    typedef struct packed {
        logic bridge_rst;
        logic stat_wr;
        logic ren;
        logic rdis;
        logic done;
    } lrs_out_t;

    function automatic lrs_out_t lrs_decode(lrs_state_e st);
        lrs_out_t o;
        o            = '0;
        o.bridge_rst = (st == ST_BRST);
        o.stat_wr    = (st == ST_WR);
        o.ren        = (st == ST_REN);
        o.rdis       = (st == ST_RDIS);
        o.done       = (st == ST_FIN);
        return o;
    endfunction

    function automatic int lrs_max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lrs_tick_timer.sv
module lrs_tick_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + TW'(1);
    end

    assign expire = tick && (cnt == (limit - TW'(1)));
endmodule

// File: rtl/lrs_try_counter.sv
module lrs_try_counter #(
    parameter int MAX_TRIES = 1000,
    localparam int NW = $clog2(MAX_TRIES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [NW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + NW'(1);
    end

    assign last = (cnt == NW'(MAX_TRIES - 1));
endmodule

// File: rtl/link_reset_seq.sv
module link_reset_seq
    import lrs_pkg::*;
#(
    parameter int BRIDGE_US = 10,
    parameter int SETTLE_US = 10,
    parameter int POLL_US   = 5,
    parameter int GAP_US    = 5,
    parameter int MAX_TRIES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic link_err,
    input  logic us_tick,
    output logic bridge_rst,
    output logic stat_wr,
    output logic remote_rst_en,
    output logic remote_rst_dis,
    output logic done,
    output logic fail
);
    localparam int LIM_MAX = lrs_max4(BRIDGE_US, SETTLE_US, POLL_US, GAP_US);
    localparam int TW      = $clog2(LIM_MAX + 1);

    lrs_state_e    state, nxt;
    lrs_out_t      outs;
    logic [TW-1:0] limit;
    logic          expire, last_try;
    logic          sample_up, sample_err, give_up;

    // window length per timed state
    always_comb begin
        case (state)
            ST_BRST:   limit = TW'(BRIDGE_US);
            ST_SETTLE: limit = TW'(SETTLE_US);
            ST_POLL:   limit = TW'(POLL_US);
            ST_GAP:    limit = TW'(GAP_US);
            default:   limit = TW'(1);
        endcase
    end

    assign sample_up  = (state == ST_POLL) && expire && !link_err;
    assign sample_err = (state == ST_POLL) && expire && link_err;
    assign give_up    = sample_err && last_try;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start)  nxt = ST_BRST;
            ST_BRST:   if (expire) nxt = ST_SETTLE;
            ST_SETTLE: if (expire) nxt = ST_WR;
            ST_WR:                 nxt = ST_POLL;
            ST_POLL: begin
                if (sample_up)       nxt = ST_REN;
                else if (give_up)    nxt = ST_FIN;
                else if (sample_err) nxt = ST_WR;
            end
            ST_REN:                nxt = ST_GAP;
            ST_GAP:    if (expire) nxt = ST_RDIS;
            ST_RDIS:               nxt = ST_FIN;
            ST_FIN:                nxt = ST_IDLE;
            default:               nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fail <= 1'b0;
        else if (state == ST_IDLE && start)
            fail <= 1'b0;
        else if (give_up)
            fail <= 1'b1;
    end

    lrs_tick_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (nxt != state),
        .tick   (us_tick),
        .limit  (limit),
        .expire (expire)
    );

    lrs_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == ST_IDLE),
        .inc  (sample_err && !last_try),
        .last (last_try)
    );

    assign outs           = lrs_decode(state);
    assign bridge_rst     = outs.bridge_rst;
    assign stat_wr        = outs.stat_wr;
    assign remote_rst_en  = outs.ren;
    assign remote_rst_dis = outs.rdis;
    assign done           = outs.done;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
    parameter int MAX_TRIES = 1000,
    localparam int CW = $clog2(MAX_TRIES + 2)
) (
    input logic clk,
    input logic rst,
    input logic bridge_rst,
    input logic stat_wr,
    input logic remote_rst_en,
    input logic remote_rst_dis,
    input logic done,
    input logic fail
);
    logic [CW-1:0] wr_seen;

    always_ff @(posedge clk) begin
        if (rst || bridge_rst)
            wr_seen <= '0;
        else if (stat_wr)
            wr_seen <= wr_seen + CW'(1);
    end

    // R1 / R8: outputs quiet right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !bridge_rst && !stat_wr && !remote_rst_en && !remote_rst_dis && !done && !fail);

    // R2: bridge reset never overlaps another strobe
    a_r2_reset_alone: assert property (@(posedge clk) disable iff (rst)
        bridge_rst |-> !stat_wr && !remote_rst_en && !remote_rst_dis && !done);

    // R3: status write strobe is one cycle wide
    a_r3_wr_single: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> !stat_wr);

    // R4: attempt budget never exceeded
    a_r4_try_bound: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> (wr_seen < CW'(MAX_TRIES)));

    // R4: no remote reset while failed
    a_r4_fail_quiet: assert property (@(posedge clk) disable iff (rst)
        fail |-> !remote_rst_en && !remote_rst_dis);

    // R5: enable strobe single cycle, not followed at once by disable
    a_r5_en_single: assert property (@(posedge clk) disable iff (rst)
        remote_rst_en |=> !remote_rst_en && !remote_rst_dis);

    // R6: done single cycle, fail rises only with done
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_fail_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> done);
endmodule

bind link_reset_seq lrs_checker #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bridge_rst     (bridge_rst),
    .stat_wr        (stat_wr),
    .remote_rst_en  (remote_rst_en),
    .remote_rst_dis (remote_rst_dis),
    .done           (done),
    .fail           (fail)
);

// File: tb/sim_link_reset_seq.sv
module sim_link_reset_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BRIDGE_US  = 10;
    localparam int SETTLE_US  = 10;
    localparam int POLL_US    = 5;
    localparam int GAP_US     = 5;
    localparam int MAX_TRIES  = 1000;
    localparam int WD_LIMIT   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic link_err = 1'b1;
    logic us_tick = 1'b0;
    logic bridge_rst, stat_wr, remote_rst_en, remote_rst_dis, done, fail;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int nfail = 0;
    int div = 0;
    // monitor state
    int rst_rise, rst_ticks, settle_ticks, wr_cnt, since, gap_bad;
    int en_cnt, dis_cnt, gap_ticks, done_cnt, done_after_dis, wide;
    logic in_poll, in_gap, p_brst, p_wr, p_ren, p_rdis, p_done;

    link_reset_seq #(
        .BRIDGE_US(BRIDGE_US), .SETTLE_US(SETTLE_US), .POLL_US(POLL_US),
        .GAP_US(GAP_US), .MAX_TRIES(MAX_TRIES)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .link_err(link_err), .us_tick(us_tick),
        .bridge_rst(bridge_rst), .stat_wr(stat_wr), .remote_rst_en(remote_rst_en),
        .remote_rst_dis(remote_rst_dis), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic clear_mon();
        rst_rise = 0; rst_ticks = 0; settle_ticks = 0; wr_cnt = 0; since = 0;
        gap_bad = 0; en_cnt = 0; dis_cnt = 0; gap_ticks = 0; done_cnt = 0;
        done_after_dis = 0; wide = 0; in_poll = 1'b0; in_gap = 1'b0;
    endtask

    initial begin
        clear_mon();
        p_brst = 0; p_wr = 0; p_ren = 0; p_rdis = 0; p_done = 0;
    end

    // tick every third cycle; link_err follows the attempt count
    always @(negedge clk) begin
        div = (div == 2) ? 0 : div + 1;
        us_tick = (div == 0);
        link_err = (wr_cnt <= nfail);
    end

    // monitor reads pre-edge values
    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            if (bridge_rst && !p_brst) rst_rise++;
            if (bridge_rst && us_tick) rst_ticks++;
            if (!bridge_rst && rst_rise > 0 && wr_cnt == 0 && us_tick) settle_ticks++;
            if (stat_wr) begin
                if (wr_cnt > 0 && since != POLL_US) gap_bad++;
                wr_cnt++; since = 0; in_poll = 1'b1;
            end else if (in_poll && us_tick) since++;
            if (remote_rst_en) begin
                en_cnt++;
                if (since != POLL_US) gap_bad++;
                in_poll = 1'b0; in_gap = 1'b1; gap_ticks = 0;
            end else if (remote_rst_dis) begin
                dis_cnt++; in_gap = 1'b0;
            end else if (in_gap && us_tick) gap_ticks++;
            if (done) begin
                done_cnt++;
                if (p_rdis) done_after_dis++;
                if (in_poll && since != POLL_US) gap_bad++;
                in_poll = 1'b0;
            end
            if ((stat_wr && p_wr) || (remote_rst_en && p_ren) ||
                (remote_rst_dis && p_rdis) || (done && p_done)) wide++;
        end
        p_brst = bridge_rst; p_wr = stat_wr; p_ren = remote_rst_en;
        p_rdis = remote_rst_dis; p_done = done;
    end

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 outputs after reset",
                 int'({bridge_rst, stat_wr, remote_rst_en, remote_rst_dis, done, fail}), 0);
        repeat (10) @(negedge clk);
        check_eq("R1 idle without start", int'(bridge_rst), 0);
    endtask

    task automatic t_success(int nf, string tag);
        nfail = nf;
        clear_mon();
        pulse_start();
        check_eq({"R2 bridge_rst high after start ", tag}, int'(bridge_rst), 1);
        wait_done();
        check_eq({"R2 bridge reset ticks ", tag}, rst_ticks, BRIDGE_US);
        check_eq({"R2 settle ticks ", tag}, settle_ticks, SETTLE_US);
        check_eq({"R3 attempts ", tag}, wr_cnt, nf + 1);
        check_eq({"R3 poll interval errors ", tag}, gap_bad, 0);
        check_eq({"R5 enable strobes ", tag}, en_cnt, 1);
        check_eq({"R5 disable strobes ", tag}, dis_cnt, 1);
        check_eq({"R5 gap ticks ", tag}, gap_ticks, GAP_US);
        check_eq({"R6 done after disable ", tag}, done_after_dis, 1);
        check_eq({"R6 fail after success ", tag}, int'(fail), 0);
        check_eq({"R3 R5 R6 strobe width ", tag}, wide, 0);
    endtask

    task automatic t_start_busy();
        nfail = 1;
        clear_mon();
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        while (wr_cnt == 0) @(negedge clk);
        pulse_start();
        wait_done();
        check_eq("R7 single bridge reset", rst_rise, 1);
        check_eq("R7 bridge reset ticks", rst_ticks, BRIDGE_US);
        check_eq("R7 attempts unchanged", wr_cnt, 2);
        check_eq("R7 single done", done_cnt, 1);
    endtask

    task automatic t_exhaust();
        nfail = 1 << 30;
        clear_mon();
        pulse_start();
        wait_done();
        check_eq("R4 attempts", wr_cnt, MAX_TRIES);
        check_eq("R4 no enable strobe", en_cnt, 0);
        check_eq("R4 no disable strobe", dis_cnt, 0);
        check_eq("R4 poll interval errors", gap_bad, 0);
        check_eq("R6 done count on fail", done_cnt, 1);
        check_eq("R4 fail raised", int'(fail), 1);
        repeat (20) @(negedge clk);
        check_eq("R6 fail held", int'(fail), 1);
    endtask

    task automatic t_reset_clears_fail();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check_eq("R8 reset clears fail", int'(fail), 0);
    endtask

    task automatic t_start_clears_fail();
        nfail = 0;
        clear_mon();
        pulse_start();
        check_eq("R6 start clears fail", int'(fail), 0);
        wait_done();
        check_eq("R6 success after failure", en_cnt, 1);
    endtask

    task automatic t_midreset();
        nfail = 1 << 30;
        clear_mon();
        pulse_start();
        while (wr_cnt < 2) @(negedge clk);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check_eq("R8 outputs after abort",
                 int'({bridge_rst, stat_wr, remote_rst_en, remote_rst_dis, done, fail}), 0);
        clear_mon();
        repeat (100) @(negedge clk);
        check_eq("R8 no activity after abort", wr_cnt + rst_rise + done_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_success(0, "first try");
        t_success(4, "retry");
        t_start_busy();
        t_exhaust();
        t_reset_clears_fail();
        t_exhaust();
        t_start_clears_fail();
        t_midreset();
        finish_run();
    end
endmodule